// File: doc/BRIEF.md
# Integer Execution Unit with Sequential Divider

This block is the arithmetic engine behind an instruction sequencer. Every operation is started by a one-cycle chip-enable strobe. The strobe carries two signed two's-complement operands and a 4-bit operation code.

Most operations produce their result at the next clock edge. Signed divide and modulo run on a bit-serial restoring divider, so they hold the unit busy for a fixed number of cycles before they deliver. Every completion raises a one-cycle done pulse.

Two compare flags, equality and signed less-than, are taken from the operands of each accepted strobe. The sequencer uses these flags to resolve branch conditions. Between strobes the result and the flags hold their values, so the sequencer can read them whenever it likes.

Top module: `int_exec_unit`

## Requirements
- R1: Operation code 0 returns opa+opb modulo 2^32. The overflow output is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it.
- R2: Code 1 returns opa-opb, and code 2 returns the low 32 bits of opa*opb. Both clear the overflow output.
- R3: Codes 5, 6 and 7 return bitwise AND, OR and XOR of the operands. Code 8 returns the bitwise inverse of opa. All of them clear overflow.
- R4: Codes 9, 10, 11 and 12 shift opa left logically, shift it right logically, rotate it left and rotate it right. The distance is opb[4:0], and overflow is cleared.
- R5: Codes 3 and 4 with a nonzero divisor return the quotient and the remainder. The quotient is truncated toward zero, and the remainder carries the dividend's sign. The unit asserts busy on the accept edge and holds it for 32 edges. It delivers result and done on the 32nd edge with overflow cleared. Dividing the most negative value by -1 yields 0x80000000.
- R6: Codes 3 and 4 with opb equal to 0 complete at the accept edge with overflow set. Code 3 returns 0xFFFFFFFF and code 4 returns opa.
- R7: On every accepted strobe, cmp_eq takes opa==opb and cmp_lt takes the signed comparison opa<opb. Both flags hold until the next accepted strobe.
- R8: With ce low and the unit idle, result, overflow and the flags keep their values, and done stays low.
- R9: A strobe that arrives while busy is high is ignored. The divide in flight completes unaltered, and the flags are not reloaded.
- R10: Codes 13, 14 and 15 return 0 with overflow cleared, and they complete at the accept edge.
- R11: While rst_n is low, result, ovf, done, busy, cmp_eq and cmp_lt are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| ce | input | 1 | Chip-enable strobe that starts an operation |
| op | input | 4 | Operation code |
| opa | input | 32 | First signed operand |
| opb | input | 32 | Second signed operand, also the shift distance |
| result | output | 32 | Result of the last completed operation |
| ovf | output | 1 | Overflow of the last completed operation |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Divider in progress |
| cmp_eq | output | 1 | Operands of the last accepted strobe were equal |
| cmp_lt | output | 1 | First operand of the last accepted strobe was less (signed) |

## Verification
A corrupted divider iteration or step count shows up only at the end of a divide. It appears as a wrong quotient or remainder, or as a done pulse one cycle early or late, 32 cycles after the strobe. For that reason random traffic mixes divides of both signs with strobes fired while busy. A stale operand or a lost sign fix-up on a single-cycle operation is visible at the very next edge.

The reference model advances through the busy window cycle by cycle. It compares every output on every clock, so a hold or strobe-ignore fault shows up at the first edge where a value moves unexpectedly.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         done,
  output logic         busy,
  output logic         cmp_eq,
  output logic         cmp_lt
);
  localparam int SW = $clog2(W);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MUL = 4'd2,
    OP_DIV = 4'd3, OP_MOD = 4'd4, OP_AND = 4'd5, OP_OR = 4'd6,
    OP_XOR = 4'd7, OP_NOT = 4'd8, OP_SHL = 4'd9, OP_SHR = 4'd10,
    OP_ROL = 4'd11, OP_ROR = 4'd12;

  logic [W-1:0]  sum, mag_a, mag_b, f_res;
  logic          f_ovf, is_div, b_zero;
  logic [SW-1:0] sh;
  logic [W-1:0]  dq, dr, dd, nq, nr, fin_q, fin_r;
  logic [W:0]    trial;
  logic          take, neg_q, neg_r, want_mod;
  logic [SW-1:0] cnt;
  logic [3:0]    op_q;

  assign sum    = opa + opb;
  assign mag_a  = opa[W-1] ? -opa : opa;
  assign mag_b  = opb[W-1] ? -opb : opb;
  assign sh     = opb[SW-1:0];
  assign is_div = (op == OP_DIV) || (op == OP_MOD);
  assign b_zero = (opb == '0);

  always_comb begin
    f_ovf = 1'b0;
    case (op)
      OP_ADD: begin
        f_res = sum;
        f_ovf = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
      end
      OP_SUB: f_res = opa - opb;
      OP_MUL: f_res = opa * opb;
      OP_DIV: begin f_res = '1;  f_ovf = 1'b1; end
      OP_MOD: begin f_res = opa; f_ovf = 1'b1; end
      OP_AND: f_res = opa & opb;
      OP_OR:  f_res = opa | opb;
      OP_XOR: f_res = opa ^ opb;
      OP_NOT: f_res = ~opa;
      OP_SHL: f_res = opa << sh;
      OP_SHR: f_res = opa >> sh;
      OP_ROL: f_res = (opa << sh) | (opa >> (W - int'(sh)));
      OP_ROR: f_res = (opa >> sh) | (opa << (W - int'(sh)));
      default: f_res = '0;
    endcase
  end

  assign trial = {dr, dq[W-1]} - {1'b0, dd};
  assign take  = ~trial[W];
  assign nr    = take ? trial[W-1:0] : {dr[W-2:0], dq[W-1]};
  assign nq    = {dq[W-2:0], take};
  assign fin_q = neg_q ? -nq : nq;
  assign fin_r = neg_r ? -nr : nr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0; ovf <= 1'b0; done <= 1'b0; busy <= 1'b0;
      cmp_eq <= 1'b0; cmp_lt <= 1'b0; op_q <= '0;
      dq <= '0; dr <= '0; dd <= '0; cnt <= '0;
      neg_q <= 1'b0; neg_r <= 1'b0; want_mod <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        dq  <= nq;
        dr  <= nr;
        cnt <= cnt + 1'b1;
        if (cnt == SW'(W - 1)) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          ovf    <= 1'b0;
          result <= want_mod ? fin_r : fin_q;
        end
      end else if (ce) begin
        cmp_eq <= (opa == opb);
        cmp_lt <= ($signed(opa) < $signed(opb));
        op_q   <= op;
        if (is_div && !b_zero) begin
          busy     <= 1'b1;
          cnt      <= '0;
          dq       <= mag_a;
          dr       <= '0;
          dd       <= mag_b;
          neg_q    <= opa[W-1] ^ opb[W-1];
          neg_r    <= opa[W-1];
          want_mod <= (op == OP_MOD);
        end else begin
          result <= f_res;
          ovf    <= f_ovf;
          done   <= 1'b1;
        end
      end
    end
  end

  a_r1_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_ADD) |-> result == $past(opa) + $past(opb));
  a_r2_ovf_only_add_div: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (op_q == OP_ADD || op_q == OP_DIV || op_q == OP_MOD));
  a_r5_end_of_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r7_flags_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cmp_eq) && $stable(cmp_lt)));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !busy) |=> ($stable(result) && $stable(ovf) && !done));
  a_r9_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
  logic        clk = 1'b0, rst_n = 1'b0, ce = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] result;
  logic        ovf, done, busy, cmp_eq, cmp_lt;

  int_exec_unit #(.W(32)) uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .op(op), .opa(opa), .opb(opb),
    .result(result), .ovf(ovf), .done(done), .busy(busy),
    .cmp_eq(cmp_eq), .cmp_lt(cmp_lt));

  always #4 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [31:0] m_res = '0, p_res = '0;
  logic        m_ovf = 0, m_done = 0, m_busy = 0, m_eq = 0, m_lt = 0;
  int          m_cnt = 0;
  string       tag;

  task automatic check(input string t, input string nm, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", t, nm, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] o, input logic [31:0] b);
    if ((o == 3 || o == 4) && b == 0) return "R6";
    case (o)
      0: return "R1";
      1, 2: return "R2";
      3, 4: return "R5";
      5, 6, 7, 8: return "R3";
      9, 10, 11, 12: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic c, input logic [3:0] o, input logic [31:0] a, b);
    logic [31:0] s;
    longint sa, sb;
    int n;
    sa = longint'($signed(a)); sb = longint'($signed(b)); n = int'(b[4:0]);
    if (m_busy) begin
      tag = "R5 R9";
      m_cnt++;
      m_done = 0;
      if (m_cnt == 32) begin
        m_busy = 0; m_done = 1; m_res = p_res; m_ovf = 0;
      end
    end else if (!c) begin
      tag = "R8"; m_done = 0;
    end else begin
      tag = op_tag(o, b);
      m_eq = (a == b); m_lt = (sa < sb);
      if ((o == 3 || o == 4) && b != 0) begin
        m_busy = 1; m_cnt = 0; m_done = 0;
        p_res = (o == 3) ? 32'(sa / sb) : 32'(sa % sb);
      end else begin
        m_done = 1; m_ovf = 0;
        case (o)
          0: begin s = a + b; m_res = s; m_ovf = (a[31] == b[31]) && (s[31] != a[31]); end
          1: m_res = a - b;
          2: m_res = a * b;
          3: begin m_res = 32'hFFFF_FFFF; m_ovf = 1; end
          4: begin m_res = a; m_ovf = 1; end
          5: m_res = a & b;
          6: m_res = a | b;
          7: m_res = a ^ b;
          8: m_res = ~a;
          9: m_res = a << n;
          10: m_res = a >> n;
          11: m_res = (a << n) | (a >> (32 - n));
          12: m_res = (a >> n) | (a << (32 - n));
          default: m_res = 0;
        endcase
      end
    end
  endtask

  task automatic step(input logic c, input logic [3:0] o, input logic [31:0] a, b);
    ce = c; op = o; opa = a; opb = b;
    model(c, o, a, b);
    @(posedge clk);
    @(negedge clk);
    check(tag, "result", result, m_res);
    check(tag, "ovf", {31'b0, ovf}, {31'b0, m_ovf});
    check(tag, "done", {31'b0, done}, {31'b0, m_done});
    check("R5", "busy", {31'b0, busy}, {31'b0, m_busy});
    check("R7", "cmp_eq", {31'b0, cmp_eq}, {31'b0, m_eq});
    check("R7", "cmp_lt", {31'b0, cmp_lt}, {31'b0, m_lt});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h8000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0;
      3: return 32'h7FFF_FFFF;
      4: return 32'($urandom_range(0, 40));
      default: return $urandom;
    endcase
  endfunction

  task automatic wait_idle();
    for (int k = 0; k < 40 && m_busy; k++) step(1'b0, 4'd0, 32'd0, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "result", result, 32'h0);
    check("R11", "flags", {26'b0, ovf, done, busy, cmp_eq, cmp_lt}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 overflow corners
    step(1, 0, 32'h7FFF_FFFF, 32'h1);
    step(1, 0, 32'h8000_0000, 32'hFFFF_FFFF);
    step(1, 0, 32'h7FFF_FFFF, 32'h8000_0000);
    // R2, R3, R4 (shift distance 37 uses low 5 bits = 5)
    step(1, 1, 32'h8000_0000, 32'h1);
    step(1, 2, 32'h1234_5678, 32'hFFFF_FFFD);
    step(1, 8, 32'h0F0F_0000, 32'h0);
    step(1, 11, 32'h8000_0001, 32'd37);
    step(1, 12, 32'h0000_0003, 32'd0);
    // R8 hold with idle
    step(0, 0, 32'h5, 32'h5);
    step(0, 9, 32'h1, 32'h1);
    // R6 divide by zero
    step(1, 3, 32'hFFFF_FFF9, 32'h0);
    step(1, 4, 32'hFFFF_FFF9, 32'h0);
    // R5 signed divide cases, R9 strobes during busy
    step(1, 3, 32'hFFFF_FFF9, 32'd2);
    step(1, 0, 32'h1, 32'h1);
    wait_idle();
    step(1, 4, 32'hFFFF_FFF9, 32'd2);
    wait_idle();
    step(1, 3, 32'h8000_0000, 32'hFFFF_FFFF);
    wait_idle();
    step(1, 4, 32'd100, 32'hFFFF_FFF9);
    wait_idle();
    step(1, 3, 32'd5, 32'h8000_0000);
    wait_idle();
    // R10 unused codes
    step(1, 13, 32'h1, 32'h2);
    step(1, 15, 32'hFFFF_FFFF, 32'h2);
    // random traffic
    for (int i = 0; i < 6000; i++)
      step($urandom_range(0, 3) != 0, 4'($urandom_range(0, 15)), pick(), pick());
    wait_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule